// File: doc/BRIEF.md
# Privilege-Mode Trap and Interrupt Sequencer

This block is the control sequencer of a small processor. It runs a three-state loop of fetch, decode and execute. It keeps the program counter, a one-bit privilege mode and a saved return context. It also holds a sixteen-slot table of handler addresses. While `fetchEn` is high, the surrounding memory supplies the instruction at `pc`, already reduced to a class code and a small argument. The datapath that carries out ordinary work is not part of the block. This block only decides where the program counter goes next and in which mode.

Control moves into supervisor mode only through an entry that reads the handler table. There are three such entries: a trap instruction, a protection fault raised when a privileged instruction is tried in user mode, and a pending interrupt. Each entry stores the return address and the prior mode, clears the mode bit and branches, all in one execute cycle. A privileged return instruction restores both stored values. A halt instruction stops the loop until reset.

Top module: `priv_trap_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `pc` equals the start address 0x0100, `mode` is 0, `halted` is 0 and `fetchEn` is 1.
- R2: Each instruction takes exactly three cycles (fetch, decode, execute). `insnClass` and `insnArg` are sampled in the cycle where `fetchEn` is 1, and `fetchEn` is never high two cycles in a row. A plain instruction (class 0, 6 or 7) advances `pc` by 4.
- R3: Halt (class 5), when executed in supervisor mode, raises `halted` for good. After that `fetchEn` stays 0 and `pc` holds the halt instruction's address until reset.
- R4: A one-cycle pulse on `irqReq` leaves one pending interrupt. After the next instruction that completes, it is entered: the saved address is the address that instruction would have continued at, `pc` becomes table slot 14, and `mode` becomes 0. It is entered only once.
- R5: A trap (class 2) stores `pc`+4 and the current mode, then sets `mode` to 0 and `pc` to the table slot chosen by `insnArg`, all in its execute cycle.
- R6: Mode 0 means supervisor and mode 1 means user. Class 4 (enter user, privileged) sets the mode to 1 and advances by 4. The mode only goes from 1 to 0 through a table entry (trap, fault or interrupt).
- R7: A privileged class (1 I/O, 3 return, 4 enter user, 5 halt) fetched in user mode is not carried out. Instead it enters through slot 15, saves its own address and the user mode, and sets `mode` to 0.
- R8: `privExec` is 1 for one cycle, in the execute cycle, exactly when a privileged instruction is carried out. This happens only in supervisor mode.
- R9: A handler table write (`cfgWe`, `cfgIdx`, `cfgData`) takes effect only while `mode` is 0. In user mode the write is ignored.
- R10: Return (class 3) sets `pc` and `mode` to the stored return address and stored mode.
- R11: An interrupt that is pending when a trap or fault is entered is not taken in that cycle. It is taken after the next instruction that completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| insnClass | input | 3 | Class code of the fetched instruction |
| insnArg | input | 4 | Trap slot number of the fetched instruction |
| irqReq | input | 1 | Interrupt request; any high cycle marks one pending |
| cfgWe | input | 1 | Handler table write strobe |
| cfgIdx | input | 4 | Handler table slot to write |
| cfgData | input | 16 | Handler address to store |
| fetchEn | output | 1 | High in the fetch cycle; memory supplies the instruction at `pc` |
| pc | output | 16 | Program counter |
| mode | output | 1 | 0 supervisor, 1 user |
| privExec | output | 1 | A privileged instruction is being carried out |
| halted | output | 1 | The sequencer has stopped |

## Verification
A corrupted handler table slot, stored return address or stored mode does not show at the ports until it is used. It appears at the next fetch after the entry or return that reads it, as a wrong `pc` or `mode`. For this reason the bench follows every entry with a return. A lost or duplicated pending interrupt shows as an unexpected `pc` at the fetch that follows the next completed instruction, three cycles after the request. A wrong state in the fetch loop shows at once as `fetchEn` arriving early or late.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_HALT   = 2'd3
  } seqState_t;

  localparam logic [2:0] OP_PLAIN = 3'd0;
  localparam logic [2:0] OP_IO    = 3'd1;
  localparam logic [2:0] OP_TRAP  = 3'd2;
  localparam logic [2:0] OP_RET   = 3'd3;
  localparam logic [2:0] OP_USER  = 3'd4;
  localparam logic [2:0] OP_HALT  = 3'd5;

  localparam logic MODE_SUP = 1'b0;
  localparam logic MODE_USR = 1'b1;

  // strobes issued by control, consumed by the datapath
  typedef struct packed {
    logic latchIr;
    logic stepPc;
    logic setUser;
    logic doRet;
    logic enterTrap;
    logic enterFault;
    logic enterIrq;
  } seqStrobe_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] irClass,
  input  logic       mode,
  input  logic       irqReq,
  output seqStrobe_t st,
  output logic       fetchEn,
  output logic       halted,
  output logic       privExec
);

  seqState_t state, stateNext;
  logic      irqPend;
  logic      isPriv, blocked, inExec, completes;

  always_comb begin
    isPriv  = (irClass == OP_IO) || (irClass == OP_RET) ||
              (irClass == OP_USER) || (irClass == OP_HALT);
    blocked = isPriv && (mode == MODE_USR);
    inExec  = (state == ST_EXEC);
  end

  always_comb begin
    st        = '0;
    completes = 1'b0;
    stateNext = state;
    case (state)
      ST_FETCH: begin
        st.latchIr = 1'b1;
        stateNext  = ST_DECODE;
      end
      ST_DECODE: stateNext = ST_EXEC;
      ST_EXEC: begin
        stateNext = ST_FETCH;
        if (blocked) begin
          st.enterFault = 1'b1;
        end else begin
          case (irClass)
            OP_TRAP: st.enterTrap = 1'b1;
            OP_RET:  begin st.doRet = 1'b1; completes = 1'b1; end
            OP_USER: begin st.stepPc = 1'b1; st.setUser = 1'b1; completes = 1'b1; end
            OP_HALT: stateNext = ST_HALT;
            default: begin st.stepPc = 1'b1; completes = 1'b1; end
          endcase
        end
        st.enterIrq = completes && irqPend;
      end
      default: stateNext = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_FETCH;
      irqPend <= 1'b0;
    end else begin
      state   <= stateNext;
      irqPend <= irqReq || (irqPend && !st.enterIrq);
    end
  end

  assign fetchEn  = (state == ST_FETCH);
  assign halted   = (state == ST_HALT);
  assign privExec = inExec && isPriv && !blocked;

  // R8: privileged work is only ever signalled in supervisor mode
  p_priv_sup_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    privExec |-> (mode == MODE_SUP));

  // R3: once stopped, stays stopped and never fetches
  p_halt_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && !fetchEn));

  // R2: fetch never repeats in consecutive cycles
  p_fetch_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    fetchEn |=> !fetchEn);

  // R11: no interrupt entry alongside a trap or fault entry
  p_irq_apart_r11: assert property (@(posedge clk) disable iff (!rstN)
    st.enterIrq |-> !(st.enterTrap || st.enterFault));

  // R4: an interrupt entry consumes the pending flag unless re-requested
  p_irq_once_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st.enterIrq && !irqReq) |=> !irqPend);

endmodule

// File: rtl/seq_dp.sv
module seq_dp
  import seq_pkg::*;
#(
  parameter int AW         = 16,
  parameter int INSN_SIZE  = 4,
  parameter logic [AW-1:0] START_ADDR = 16'h0100,
  parameter int SLOTS      = 16,
  parameter int IRQ_SLOT   = 14,
  parameter int FAULT_SLOT = 15,
  parameter int SW         = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    st,
  input  logic [2:0]    insnClass,
  input  logic [SW-1:0] insnArg,
  input  logic          cfgWe,
  input  logic [SW-1:0] cfgIdx,
  input  logic [AW-1:0] cfgData,
  output logic [2:0]    irClass,
  output logic [AW-1:0] pc,
  output logic          mode
);

  logic [SW-1:0] irArg;
  logic [AW-1:0] savedPc;
  logic          savedMode;
  logic [AW-1:0] tbl [SLOTS];
  logic [AW-1:0] pcPlus, nextPc;
  logic          nextMode;

  // instruction register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irClass <= OP_PLAIN;
      irArg   <= '0;
    end else if (st.latchIr) begin
      irClass <= insnClass;
      irArg   <= insnArg;
    end
  end

  // handler table, writable from supervisor mode only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) tbl[i] <= '0;
    end else if (cfgWe && (mode == MODE_SUP)) begin
      for (int i = 0; i < SLOTS; i++)
        if (cfgIdx == SW'(i)) tbl[i] <= cfgData;
    end
  end

  always_comb begin
    pcPlus   = pc + AW'(INSN_SIZE);
    nextPc   = st.doRet ? savedPc : pcPlus;
    nextMode = st.doRet ? savedMode : (st.setUser ? MODE_USR : mode);
  end

  // program counter, mode and return context
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc        <= START_ADDR;
      mode      <= MODE_SUP;
      savedPc   <= '0;
      savedMode <= MODE_SUP;
    end else if (st.enterIrq) begin
      savedPc   <= nextPc;
      savedMode <= nextMode;
      pc        <= tbl[IRQ_SLOT];
      mode      <= MODE_SUP;
    end else if (st.enterTrap) begin
      savedPc   <= pcPlus;
      savedMode <= mode;
      pc        <= tbl[irArg];
      mode      <= MODE_SUP;
    end else if (st.enterFault) begin
      savedPc   <= pc;
      savedMode <= mode;
      pc        <= tbl[FAULT_SLOT];
      mode      <= MODE_SUP;
    end else if (st.doRet || st.stepPc) begin
      pc   <= nextPc;
      mode <= nextMode;
    end
  end

  // R1: first cycle out of reset starts at the hardwired address
  p_reset_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pc == START_ADDR && mode == MODE_SUP));

  // R6: supervisor is reached only through a table entry
  p_sup_via_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mode) |-> $past(st.enterTrap || st.enterFault || st.enterIrq));

  // R5: a trap lands on its table slot in supervisor mode
  p_trap_target_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.enterTrap && !st.enterIrq) |=> (pc == $past(tbl[irArg]) && mode == MODE_SUP));

  // R7: a fault saves its own address
  p_fault_save_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.enterFault |=> (savedPc == $past(pc) && savedMode == MODE_USR));

endmodule

// File: rtl/priv_trap_seq.sv
module priv_trap_seq
  import seq_pkg::*;
#(
  parameter int AW         = 16,
  parameter int INSN_SIZE  = 4,
  parameter logic [AW-1:0] START_ADDR = 16'h0100,
  parameter int SLOTS      = 16,
  parameter int IRQ_SLOT   = 14,
  parameter int FAULT_SLOT = 15,
  localparam int SW        = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    insnClass,
  input  logic [SW-1:0] insnArg,
  input  logic          irqReq,
  input  logic          cfgWe,
  input  logic [SW-1:0] cfgIdx,
  input  logic [AW-1:0] cfgData,
  output logic          fetchEn,
  output logic [AW-1:0] pc,
  output logic          mode,
  output logic          privExec,
  output logic          halted
);

  seqStrobe_t strobes;
  logic [2:0] irClass;

  seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .irClass  (irClass),
    .mode     (mode),
    .irqReq   (irqReq),
    .st       (strobes),
    .fetchEn  (fetchEn),
    .halted   (halted),
    .privExec (privExec)
  );

  seq_dp #(
    .AW         (AW),
    .INSN_SIZE  (INSN_SIZE),
    .START_ADDR (START_ADDR),
    .SLOTS      (SLOTS),
    .IRQ_SLOT   (IRQ_SLOT),
    .FAULT_SLOT (FAULT_SLOT),
    .SW         (SW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (strobes),
    .insnClass (insnClass),
    .insnArg   (insnArg),
    .cfgWe     (cfgWe),
    .cfgIdx    (cfgIdx),
    .cfgData   (cfgData),
    .irClass   (irClass),
    .pc        (pc),
    .mode      (mode)
  );

endmodule

// File: tb/priv_trap_seq_tb.sv
`timescale 1ns/1ps
module priv_trap_seq_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  insnClass;
  logic [3:0]  insnArg;
  logic        irqReq, cfgWe;
  logic [3:0]  cfgIdx;
  logic [15:0] cfgData;
  logic        fetchEn, mode, privExec, halted;
  logic [15:0] pc;

  int  total = 0;
  int  fails = 0;
  bit  done  = 0;
  bit  lastSaw;

  always #4 clk = ~clk;

  priv_trap_seq u_dut (
    .clk(clk), .rstN(rstN), .insnClass(insnClass), .insnArg(insnArg),
    .irqReq(irqReq), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .fetchEn(fetchEn), .pc(pc), .mode(mode), .privExec(privExec), .halted(halted)
  );

  function automatic logic [15:0] slotAddr(int k);
    return 16'h1000 + 16'(k * 64);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one instruction: wait for fetch, check pc, present it, run decode and execute
  task automatic issue(input logic [2:0] cls, input logic [3:0] arg, input logic [15:0] expPc,
                       input string req, input bit we = 0, input logic [3:0] idx = 0,
                       input logic [15:0] data = 0, input bit irq = 0);
    int g = 0;
    while (!fetchEn && g < 8) begin @(negedge clk); g++; end
    chk(fetchEn === 1'b1 && pc === expPc, req, {15'd0, fetchEn, pc}, {16'd1, expPc});
    insnClass = cls; insnArg = arg;
    cfgWe = we; cfgIdx = idx; cfgData = data; irqReq = irq;
    @(negedge clk);
    cfgWe = 0; irqReq = 0; insnClass = 3'd0; insnArg = 4'd0;
    @(negedge clk);
    lastSaw = privExec;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] p;
    logic [15:0] trapPc;
    logic [2:0]  privCls [4];
    privCls[0] = 3'd1; privCls[1] = 3'd3; privCls[2] = 3'd4; privCls[3] = 3'd5;
    rstN = 0; insnClass = 0; insnArg = 0; irqReq = 0; cfgWe = 0; cfgIdx = 0; cfgData = 0;
    repeat (3) @(negedge clk);
    chk(pc === 16'h0100, "R1 pc in reset", pc, 16'h0100);
    rstN = 1;
    chk(fetchEn === 1'b1, "R1 fetchEn", fetchEn, 1);
    chk(mode === 1'b0, "R1 mode", mode, 0);
    chk(halted === 1'b0, "R1 halted", halted, 0);
    p = 16'h0100;

    // R2 R9: plain instructions while filling every table slot in supervisor mode
    for (int i = 0; i < 16; i++) begin
      issue(3'd0, 0, p, "R2 plain advance", 1, 4'(i), slotAddr(i));
      chk(lastSaw == 0, "R8 plain not privileged", lastSaw, 0);
      p += 4;
    end

    // R5 R10: trap to each slot, then return
    for (int k = 0; k < 16; k++) begin
      trapPc = p;
      issue(3'd2, 4'(k), p, "R2 before trap");
      chk(mode === 1'b0, "R5 trap mode", mode, 0);
      issue(3'd3, 0, slotAddr(k), "R5 trap target");
      p = trapPc + 4;
    end

    // R8: supervisor I/O runs
    issue(3'd1, 0, p, "R10 return address");
    chk(lastSaw == 1, "R8 privExec in supervisor", lastSaw, 1);
    p += 4;

    // R6: enter user mode
    issue(3'd4, 0, p, "R2 before enter-user");
    chk(mode === 1'b1, "R6 user mode set", mode, 1);
    p += 4;

    // R7: every privileged class faults in user mode
    for (int c = 0; c < 4; c++) begin
      issue(privCls[c], 0, p, "R7 faulting fetch");
      chk(lastSaw == 0, "R7 blocked no privExec", lastSaw, 0);
      chk(mode === 1'b0, "R7 fault mode", mode, 0);
      chk(halted === 1'b0, "R7 no halt in user", halted, 0);
      issue(3'd3, 0, slotAddr(15), "R7 fault slot");
      chk(mode === 1'b1, "R10 mode restored", mode, 1);
    end

    // R9: user write ignored, seen through a trap to that slot
    issue(3'd0, 0, p, "R7 return to faulting pc", 1, 4'd2, 16'hBEEF);
    p += 4;
    issue(3'd2, 4'd2, p, "R2 before trap 2");
    issue(3'd3, 0, slotAddr(2), "R9 user write ignored");
    p += 4;
    chk(mode === 1'b1, "R10 back to user", mode, 1);

    // R4: interrupt from user mode
    issue(3'd0, 0, p, "R10 after return", 0, 0, 0, 1);
    p += 4;
    chk(mode === 1'b0, "R4 irq mode", mode, 0);
    issue(3'd3, 0, slotAddr(14), "R4 irq slot");
    chk(mode === 1'b1, "R4 user restored", mode, 1);
    issue(3'd0, 0, p, "R4 saved address");
    p += 4;
    issue(3'd0, 0, p, "R4 taken once");
    p += 4;

    // R11: interrupt raised with a trap is deferred one instruction
    trapPc = p;
    issue(3'd2, 4'd3, p, "R2 before trap 3", 0, 0, 0, 1);
    issue(3'd0, 0, slotAddr(3), "R11 trap first");
    issue(3'd3, 0, slotAddr(14), "R11 irq after next");
    issue(3'd5, 0, slotAddr(3) + 4, "R11 saved address");

    // R3: halt
    repeat (6) @(negedge clk);
    chk(halted === 1'b1, "R3 halted", halted, 1);
    chk(fetchEn === 1'b0, "R3 no fetch", fetchEn, 0);
    chk(pc === slotAddr(3) + 4, "R3 pc holds", pc, slotAddr(3) + 4);

    // R1: reset again
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    chk(pc === 16'h0100, "R1 restart pc", pc, 16'h0100);
    chk(halted === 1'b0 && mode === 1'b0, "R1 restart state", {halted, mode}, 0);
    issue(3'd0, 0, 16'h0100, "R1 first fetch");
    issue(3'd0, 0, 16'h0104, "R2 resume");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule